// File: doc/BRIEF.md
# Block-or-Page Promotion Controller

This block sits behind the page-redirection lookup of a two-tier memory built from a fast and a slow device. Each request names a tracked page entry and a 128-byte section of that 4 KiB page, and carries the result of the fast/slow lookup. For a page already in fast memory, the block steers the access to the fast-page path. For a slow page, it either finds the section in a small reserved fast zone that works like a cache, moves only that section into the zone, or orders a full page swap once the page has been touched densely enough.

Each tracked page has a touch bitmap with one bit per section. A miss that still leaves the page sparse sets the section's bit and issues a block move into a 4-way set-associative zone with tree pseudo-LRU replacement. A miss that pushes the count of set bits above the threshold issues a page swap instead. The swap clears the bitmap and drops every zone line of that page. The threshold is either a fixed value taken from an input or an adaptive register, selected by a mode pin. Requests enter through a valid/ready port. Each accepted request yields one command on a registered valid/ready output, and the controller holds at most one command at a time.

Top module: `promo_ctrl`

## Requirements
- R1: After reset, `cmd_valid` is low, `req_ready` is high, every zone line is invalid, every page bitmap is empty and the adaptive threshold equals ADAPT_INIT.
- R2: A request is taken when `req_valid && req_ready`. `req_ready` is high exactly when `cmd_valid` is low or `cmd_ready` is high. The command appears on the edge that takes the request. While `cmd_valid && !cmd_ready`, every `cmd_*` field holds its value.
- R3: A request with `req_fast`=1 gives kind 0 (fast page), `cmd_tgt_fast`=1, `cmd_rsel`=0 and `cmd_way`=0. It changes no bitmap, zone line or threshold.
- R4: A slow request whose section matches a valid zone line gives kind 1 (zone hit), `cmd_tgt_fast`=1, `cmd_rsel`=1 and `cmd_way`=the hit way. It sets no bitmap bit.
- R5: A slow request that misses the zone sets its section bit. If the page's set-bit count, including the new bit, is at most the active threshold, the command is kind 2 (block move) with `cmd_tgt_fast`=0, `cmd_rsel`=2 and `cmd_way`=the way filled.
- R6: If that count is above the threshold, the command is kind 3 (page swap) with `cmd_tgt_fast`=0, `cmd_rsel`=2 and `cmd_way`=0. The page's bitmap becomes empty and all zone lines of the page become invalid.
- R7: A fill uses the lowest-numbered invalid way of the set. If all ways are valid, it uses the tree victim. With tree bits b0,b1,b2: if b0=0 the victim is way b1 (0 or 1), otherwise way 2+b2.
- R8: Every hit and every fill updates the set's tree. Way 0 sets b0=1,b1=1; way 1 sets b0=1,b1=0; way 2 sets b0=0,b2=1; way 3 sets b0=0,b2=0. The tree starts at 000.
- R9: `mode_adapt`=0 uses `thr_fixed` as the threshold, and `mode_adapt`=1 uses the adaptive register. The register is updated in both modes. It rises by 1 on a page swap, with a ceiling of sections-1. It falls by 1 on a block move that evicts a valid line, with a floor of 1.
- R10: The zone set is the low 2 bits of the section number. A line matches only when both its page and its full section number are equal to the request's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_page | input | PAGE_W (4) | Tracked page entry index |
| req_sect | input | SECT_W (5) | 128-byte section within the page |
| req_fast | input | 1 | Lookup says the page lives in fast memory |
| mode_adapt | input | 1 | 0 fixed threshold, 1 adaptive threshold |
| thr_fixed | input | SECT_W+1 | Fixed threshold value |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command consumer ready |
| cmd_kind | output | 2 | 0 fast page, 1 zone hit, 2 block move, 3 page swap |
| cmd_tgt_fast | output | 1 | Device read first: 1 fast, 0 slow |
| cmd_rsel | output | 2 | Return-data select: 0 fast page, 1 zone, 2 slow |
| cmd_way | output | 2 | Zone way hit or filled |
| cmd_page | output | PAGE_W | Page of the command |
| cmd_sect | output | SECT_W | Section of the command |

## Verification
The assertions assume that `mode_adapt` and `thr_fixed` are steady while a request is taken. They also assume that the consumer never drops `cmd_ready` in a way that needs the held command to change. The bench therefore changes those pins only when no request is offered. It holds each command for a random number of cycles before it raises `cmd_ready`. Pages are limited to a few entries and sections to a few sets, so evictions, adaptive steps and swaps happen often.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [1:0] {K_FAST = 2'd0, K_ZHIT = 2'd1, K_BMOVE = 2'd2, K_PSWAP = 2'd3} kind_t;
  typedef enum logic [1:0] {SEL_FAST = 2'd0, SEL_ZONE = 2'd1, SEL_SLOW = 2'd2} rsel_t;

  // Tree victim: b0 picks the half, b1/b2 pick the way inside it.
  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  // Point the tree away from the way just used.
  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin n[0] = 1'b1; n[1] = (w == 2'd0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2'd2); end
    return n;
  endfunction
endpackage

// File: rtl/prom_bitmap.sv
module prom_bitmap #(
  parameter int PAGE_W = 4,
  parameter int SECT_W = 5,
  localparam int PAGES = 1 << PAGE_W,
  localparam int SECTS = 1 << SECT_W,
  localparam int CNT_W = SECT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic              set_en,
  input  logic              clr_en,
  output logic [CNT_W-1:0]  cnt_after
);
  logic [SECTS-1:0] bm [PAGES];
  logic [SECTS-1:0] merged;

  always_comb begin
    merged = bm[rd_page] | (SECTS'(1) << rd_sect);
    cnt_after = '0;
    for (int i = 0; i < SECTS; i++) cnt_after = cnt_after + CNT_W'(merged[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) bm[p] <= '0;
    end else if (clr_en) begin
      bm[rd_page] <= '0;
    end else if (set_en) begin
      bm[rd_page][rd_sect] <= 1'b1;
    end
  end

  AST_SWAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> bm[$past(rd_page)] == '0) else $error("swap left bits"); // R6
  AST_MISS_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> bm[$past(rd_page)][$past(rd_sect)]) else $error("bit not set"); // R5
endmodule

// File: rtl/prom_zone.sv
module prom_zone
  import prom_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int SECT_W = 5,
  parameter int SET_W  = 2,
  localparam int SETS  = 1 << SET_W,
  localparam int WAYS  = 4,
  localparam int TAG_W = PAGE_W + SECT_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic [SECT_W-1:0] lk_sect,
  input  logic              touch_en,
  input  logic              fill_en,
  input  logic              inval_en,
  output logic              hit,
  output logic [1:0]        hit_way,
  output logic [1:0]        fill_way,
  output logic              fill_evicts
);
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAYS-1:0]  vld  [SETS];
  logic [2:0]       tree [SETS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  hit_vec;
  logic             any_free;

  assign set_idx = lk_sect[SET_W-1:0];
  assign tag     = {lk_page, lk_sect[SECT_W-1:SET_W]};

  always_comb begin
    hit_vec  = '0;
    hit_way  = '0;
    fill_way = plru_victim(tree[set_idx]);
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld[set_idx][w] && (tags[set_idx][w] == tag);
      if (hit_vec[w]) hit_way = 2'(w);
      if (!vld[set_idx][w]) begin fill_way = 2'(w); any_free = 1'b1; end
    end
    hit = |hit_vec;
    fill_evicts = !any_free;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        tree[s] <= 3'b000;
        for (int w = 0; w < WAYS; w++) tags[s][w] <= '0;
      end
    end else begin
      if (inval_en) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (tags[s][w][TAG_W-1 -: PAGE_W] == lk_page) vld[s][w] <= 1'b0;
      end
      if (fill_en) begin
        vld[set_idx][fill_way]  <= 1'b1;
        tags[set_idx][fill_way] <= tag;
        tree[set_idx]           <= plru_touch(tree[set_idx], fill_way);
      end else if (touch_en) begin
        tree[set_idx] <= plru_touch(tree[set_idx], hit_way);
      end
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("tag matched twice"); // R10
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld[$past(set_idx)][$past(fill_way)]) else $error("fill lost"); // R7
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !hit) else $error("fill on hit"); // R5
endmodule

// File: rtl/promo_ctrl.sv
module promo_ctrl
  import prom_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int SECT_W     = 5,
  parameter int SET_W      = 2,
  parameter int ADAPT_INIT = 4,
  localparam int CNT_W     = SECT_W + 1,
  localparam int THR_MAX   = (1 << SECT_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [SECT_W-1:0] req_sect,
  input  logic              req_fast,
  input  logic              mode_adapt,
  input  logic [CNT_W-1:0]  thr_fixed,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic              cmd_tgt_fast,
  output logic [1:0]        cmd_rsel,
  output logic [1:0]        cmd_way,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [SECT_W-1:0] cmd_sect
);
  logic             take;
  logic [CNT_W-1:0] thr_ad, thr_use, cnt_after;
  logic             z_hit, z_evicts;
  logic [1:0]       z_hit_way, z_fill_way;
  kind_t            kind;

  assign req_ready = !cmd_valid || cmd_ready;
  assign take      = req_valid && req_ready;
  assign thr_use   = mode_adapt ? thr_ad : thr_fixed;

  // Stage 1: pick the device and the promotion granularity.
  always_comb begin
    if (req_fast)                 kind = K_FAST;
    else if (z_hit)               kind = K_ZHIT;
    else if (cnt_after > thr_use) kind = K_PSWAP;
    else                          kind = K_BMOVE;
  end

  prom_bitmap #(.PAGE_W(PAGE_W), .SECT_W(SECT_W)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .rd_page(req_page), .rd_sect(req_sect),
    .set_en(take && kind == K_BMOVE), .clr_en(take && kind == K_PSWAP),
    .cnt_after(cnt_after)
  );

  // Stage 2: relocation bookkeeping in the zone.
  prom_zone #(.PAGE_W(PAGE_W), .SECT_W(SECT_W), .SET_W(SET_W)) u_zone (
    .clk(clk), .rst_n(rst_n), .lk_page(req_page), .lk_sect(req_sect),
    .touch_en(take && kind == K_ZHIT), .fill_en(take && kind == K_BMOVE),
    .inval_en(take && kind == K_PSWAP),
    .hit(z_hit), .hit_way(z_hit_way), .fill_way(z_fill_way), .fill_evicts(z_evicts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_ad <= CNT_W'(ADAPT_INIT);
    end else if (take && kind == K_PSWAP) begin
      if (thr_ad < CNT_W'(THR_MAX)) thr_ad <= thr_ad + 1'b1;
    end else if (take && kind == K_BMOVE && z_evicts) begin
      if (thr_ad > CNT_W'(1)) thr_ad <= thr_ad - 1'b1;
    end
  end

  // Stage 3: registered command with return-data select.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid    <= 1'b0;
      cmd_kind     <= '0;
      cmd_tgt_fast <= 1'b0;
      cmd_rsel     <= '0;
      cmd_way      <= '0;
      cmd_page     <= '0;
      cmd_sect     <= '0;
    end else if (take) begin
      cmd_valid <= 1'b1;
      cmd_kind  <= kind;
      cmd_page  <= req_page;
      cmd_sect  <= req_sect;
      unique case (kind)
        K_FAST:  begin cmd_tgt_fast <= 1'b1; cmd_rsel <= SEL_FAST; cmd_way <= '0;         end
        K_ZHIT:  begin cmd_tgt_fast <= 1'b1; cmd_rsel <= SEL_ZONE; cmd_way <= z_hit_way;  end
        K_BMOVE: begin cmd_tgt_fast <= 1'b0; cmd_rsel <= SEL_SLOW; cmd_way <= z_fill_way; end
        K_PSWAP: begin cmd_tgt_fast <= 1'b0; cmd_rsel <= SEL_SLOW; cmd_way <= '0;         end
      endcase
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid &&
      $stable({cmd_kind, cmd_tgt_fast, cmd_rsel, cmd_way, cmd_page, cmd_sect}))
    else $error("command changed under back-pressure"); // R2
  AST_TAKE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cmd_valid) else $error("taken request gave no command"); // R2
  AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ad >= CNT_W'(1) && thr_ad <= CNT_W'(THR_MAX)) else $error("threshold out of range"); // R9
  AST_FAST_KEEPS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_fast) |=> $stable(thr_ad)) else $error("fast request moved threshold"); // R3
endmodule

// File: tb/tb_promo_ctrl.sv
`timescale 1ns/1ps
module tb_promo_ctrl;
  localparam int PAGE_W = 4, SECT_W = 5, CNT_W = 6, ADAPT_INIT = 4, THR_MAX = 31;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_fast = 0, mode_adapt = 0, cmd_ready = 0;
  logic [PAGE_W-1:0] req_page = '0;
  logic [SECT_W-1:0] req_sect = '0;
  logic [CNT_W-1:0]  thr_fixed = 6'd2;
  logic req_ready, cmd_valid, cmd_tgt_fast;
  logic [1:0] cmd_kind, cmd_rsel, cmd_way;
  logic [PAGE_W-1:0] cmd_page;
  logic [SECT_W-1:0] cmd_sect;

  always #4 clk = ~clk;

  promo_ctrl dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state, kept as plain integers.
  bit bm [16][32];
  bit vld [4][4];
  int tpg [4][4], tsc [4][4], tree [4];
  int thr_ad;
  int e_kind, e_tgt, e_rsel, e_way;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int victim(input int t);
    if ((t & 1) == 0) return ((t >> 1) & 1) ? 1 : 0;
    return ((t >> 2) & 1) ? 3 : 2;
  endfunction

  function automatic int touch(input int t, input int w);
    int n = t;
    if (w < 2) begin n = n | 1; n = (w == 0) ? (n | 2) : (n & ~2); end
    else       begin n = n & ~1; n = (w == 2) ? (n | 4) : (n & ~4); end
    return n;
  endfunction

  task automatic model(input int pg, input int sc, input bit fast);
    int set = sc % 4, hw = -1, cnt = 0, thr, fw = -1;
    if (fast) begin e_kind = 0; e_tgt = 1; e_rsel = 0; e_way = 0; return; end
    for (int w = 0; w < 4; w++) if (vld[set][w] && tpg[set][w] == pg && tsc[set][w] == sc) hw = w;
    if (hw >= 0) begin
      e_kind = 1; e_tgt = 1; e_rsel = 1; e_way = hw; tree[set] = touch(tree[set], hw); return;
    end
    for (int i = 0; i < 32; i++) cnt += (bm[pg][i] || i == sc) ? 1 : 0;
    thr = mode_adapt ? thr_ad : int'(thr_fixed);
    e_tgt = 0; e_rsel = 2;
    if (cnt > thr) begin
      e_kind = 3; e_way = 0;
      for (int i = 0; i < 32; i++) bm[pg][i] = 0;
      for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) if (tpg[s][w] == pg) vld[s][w] = 0;
      if (thr_ad < THR_MAX) thr_ad++;
    end else begin
      e_kind = 2;
      bm[pg][sc] = 1;
      for (int w = 3; w >= 0; w--) if (!vld[set][w]) fw = w;
      if (fw < 0) begin fw = victim(tree[set]); if (thr_ad > 1) thr_ad--; end
      vld[set][fw] = 1; tpg[set][fw] = pg; tsc[set][fw] = sc;
      tree[set] = touch(tree[set], fw);
      e_way = fw;
    end
  endtask

  function automatic string ktag(input int k);
    if (mode_adapt && k >= 2) return "R9";
    case (k) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
  endfunction

  task automatic cmp_all(input string tag, input int pg, input int sc);
    chk(tag, {cmd_valid, cmd_kind, cmd_tgt_fast, cmd_rsel, cmd_page, cmd_sect},
        {1'b1, 2'(e_kind), 1'(e_tgt), 2'(e_rsel), 4'(pg), 5'(sc)});
    chk("R7 R8 R10 way", cmd_way, e_way);
  endtask

  task automatic send(input int pg, input int sc, input bit fast, input int hold);
    @(negedge clk);
    chk("R2 ready idle", req_ready, 1);
    req_valid = 1; req_page = 4'(pg); req_sect = 5'(sc); req_fast = fast; cmd_ready = 0;
    model(pg, sc, fast);
    @(negedge clk);
    req_valid = 0;
    cmp_all(ktag(e_kind), pg, sc);
    chk("R2 blocked", req_ready, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      cmp_all("R2 hold", pg, sc);
    end
    cmd_ready = 1;
    @(negedge clk);
    chk("R2 drained", cmd_valid, 0);
    cmd_ready = 0;
  endtask

  initial begin
    for (int p = 0; p < 16; p++) for (int i = 0; i < 32; i++) bm[p][i] = 0;
    for (int s = 0; s < 4; s++) begin
      tree[s] = 0;
      for (int w = 0; w < 4; w++) begin vld[s][w] = 0; tpg[s][w] = -1; tsc[s][w] = -1; end
    end
    thr_ad = ADAPT_INIT;
    repeat (3) @(negedge clk);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    rst_n = 1;
    // Fixed threshold 2.
    send(3, 0, 1, 1);          // R3 fast page
    send(1, 4, 0, 2);          // R5 block move, set 0 way 0
    send(1, 4, 0, 0);          // R4 zone hit
    send(1, 5, 0, 1);          // R5 second bit
    send(1, 8, 0, 0);          // R6 third bit > 2 -> swap
    send(1, 4, 0, 0);          // R6 line gone -> block move again
    for (int p = 2; p <= 6; p++) send(p, 2, 0, 0); // R7 fills then victim
    send(2, 2, 0, 1);          // R7 R8 tree victim after refill
    send(6, 2, 0, 0);          // R4 hit on refilled way
    // Adaptive threshold.
    mode_adapt = 1;
    send(7, 1, 0, 0); send(7, 9, 0, 0); send(7, 17, 0, 0);
    for (int i = 0; i < 8; i++) send(8, i * 4 + 3, 0, 0); // R9
    // Random mix.
    for (int n = 0; n < 400; n++) begin
      if (n % 40 == 0) begin
        mode_adapt = $urandom_range(0, 1);
        thr_fixed = 6'($urandom_range(1, 6));
      end
      send($urandom_range(0, 3), $urandom_range(0, 11), ($urandom_range(0, 4) == 0),
           $urandom_range(0, 2));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule